// File: doc/BRIEF.md
# Lockable GPIO Port Register Bank

This block is the register bank behind one 16-pin general-purpose I/O port. It sits on a simple 32-bit register bus. It holds three kinds of state:

- the output data driven to the pins;
- a 4-bit mode field for every pin, spread over two mode words;
- a 2-bit drive-strength field for the whole port.

Mode and drive strength leave the block only as configuration outputs. The pad logic elsewhere on the chip interprets them.

Software changes the output data in one of two ways. It can replace the whole word, or it can use three alias registers that set, clear or invert only the bits marked in the written pattern. These aliases let software change single pins without a read-modify-write sequence. The input pins pass through a two-flop synchronizer before software reads them.

Configuration is protected at two levels:

- **Port lock.** A keyed lock register protects the whole port configuration.
- **Pin guards.** A guard bit per pin freezes that pin's mode field and output bit once software has cleared the bit. A cleared guard bit stays cleared until reset.

The bus request side is valid/ready. Ready is always high, so the bus never sees back-pressure and every request is taken in the cycle it is presented. A read answers exactly one cycle later with a single-cycle `rsp_valid` pulse together with its data. The response side has no ready, so the requester must accept the data in that cycle. Writes produce no response.

Top module: `gpio_lock_bank`

## Requirements
- R1: After reset the following hold. `pin_out` is 0. `pin_mode` is 0. `drive_mode` is 0. The pin-guard register (offset 0x20) reads 0x0000FFFF. The lock register (offset 0x24) reads 0 and `cfg_locked` is 0.
- R2: A write to offset 0x0C replaces the output data with bits [15:0] of the write data. The replacement applies only to pins whose guard bit is 1.
- R3: The output data has three alias registers, each acting on guarded-open pins only:
  - offset 0x10 sets the output bits that are 1 in the pattern;
  - offset 0x14 clears the output bits that are 1 in the pattern;
  - offset 0x18 inverts the output bits that are 1 in the pattern;
  - with all three, bits that are 0 in the pattern are left unchanged.
- R4: The mode field of pin p is laid out as follows:
  - pins 0-7 sit at bits [4p+3:4p] of offset 0x04;
  - pins 8-15 sit at bits [4(p-8)+3:4(p-8)] of offset 0x08;
  - both words read back as written;
  - on the `pin_mode` output, pin p appears at bits [4p+3:4p].
- R5: The drive field occupies bits [1:0] of offset 0x00 and is exported on `drive_mode`. Its encodings are 0 standard, 1 lowest, 2 high and 3 low. Other bits of offset 0x00 read as 0.
- R6: Writing the pin-guard register (offset 0x20) can only clear bits: the new value is the old value AND the written bits [15:0]. A pin whose guard bit is 0 keeps its mode field and its output bit through any write.
- R7: The lock register at offset 0x24 works as follows:
  - writing exactly 0x0000A543 unlocks the port;
  - writing any other value locks it;
  - a read returns 0 when unlocked and 1 when locked;
  - `cfg_locked` mirrors the lock state.
- R8: While the port is locked, writes to offsets 0x00, 0x04, 0x08 and 0x20 are ignored. Writes to the output data and its aliases (0x0C-0x18) still take effect.
- R9: A read of offset 0x1C returns `pin_in` in bits [15:0] and 0 above. The value is taken through a two-flop synchronizer: a change on `pin_in` is visible to a read that is accepted two clock edges after the change.
- R10: The bus behaves as follows:
  - `req_ready` is always 1;
  - a read accepted at an edge raises `rsp_valid` for the following cycle, with its data on `rsp_rdata`;
  - writes raise no response;
  - reads of the alias registers or of unmapped offsets (0x28-0x3C) return 0;
  - writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready, always 1 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 6 | Byte offset of the register; bits [1:0] are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output data to the pads |
| pin_mode | output | 64 | Per-pin 4-bit mode fields, pin p at bits [4p+3:4p] |
| drive_mode | output | 2 | Port drive-strength field |
| cfg_locked | output | 1 | Port configuration lock state |

## Verification
The bench builds the block with its default parameters: 16 pins, 4-bit mode fields, a 2-bit drive field and a two-stage synchronizer. With these values both mode words are full, so the split of the mode fields across the two registers is exercised on every bit position. The two-stage depth also lets a read placed one edge after an input change show the old value and the next read show the new one. Guard clearing and locking are combined, so locked configuration writes, guarded output bits and still-open data writes can all be observed on the same port state.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  localparam logic [IDX_W-1:0] IDX_DRIVE   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_MODE_LO = 4'd1;
  localparam logic [IDX_W-1:0] IDX_MODE_HI = 4'd2;
  localparam logic [IDX_W-1:0] IDX_OUT     = 4'd3;
  localparam logic [IDX_W-1:0] IDX_SET     = 4'd4;
  localparam logic [IDX_W-1:0] IDX_CLR     = 4'd5;
  localparam logic [IDX_W-1:0] IDX_FLIP    = 4'd6;
  localparam logic [IDX_W-1:0] IDX_IN      = 4'd7;
  localparam logic [IDX_W-1:0] IDX_GUARD   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_KEY     = 4'd9;

  typedef enum logic [1:0] {
    OUT_LOAD = 2'd0,
    OUT_SET  = 2'd1,
    OUT_CLR  = 2'd2,
    OUT_FLIP = 2'd3
  } out_op_e;

  typedef enum logic [1:0] {
    DRV_STANDARD = 2'd0,
    DRV_LOWEST   = 2'd1,
    DRV_HIGH     = 2'd2,
    DRV_LOW      = 2'd3
  } drive_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  out_op_e      op,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] guard,
  output logic [W-1:0] out_q
);
  logic [W-1:0] candidate;

  always_comb begin
    unique case (op)
      OUT_LOAD: candidate = pattern;
      OUT_SET:  candidate = out_q | pattern;
      OUT_CLR:  candidate = out_q & ~pattern;
      OUT_FLIP: candidate = out_q ^ pattern;
      default:  candidate = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= '0;
    else if (wr_en) out_q <= (candidate & guard) | (out_q & ~guard);
  end

  // R6: guarded pins never move
  assert_guarded_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_q & ~$past(guard)) == ($past(out_q) & ~$past(guard))));

  // R3: a set write leaves every open pattern bit high
  assert_set_bits_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OUT_SET) |=> ((out_q & $past(pattern & guard)) == $past(pattern & guard)));

  // R3: a clear write leaves every open pattern bit low
  assert_clr_bits_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OUT_CLR) |=> ((out_q & $past(pattern & guard)) == '0));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int unsigned NPINS   = 16,
  parameter int unsigned MODE_W  = 4,
  parameter int unsigned DRIVE_W = 2,
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] KEY     = 32'h0000_A543
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      drive_we,
  input  logic [((NPINS*MODE_W+DATA_W-1)/DATA_W)-1:0] mode_we,
  input  logic                      guard_we,
  input  logic                      key_we,
  output logic [DRIVE_W-1:0]        drive_q,
  output logic [NPINS*MODE_W-1:0]   mode_flat,
  output logic [NPINS-1:0]          guard_q,
  output logic                      locked_q
);
  localparam int unsigned PINS_PER_WORD = DATA_W / MODE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     locked_q <= 1'b0;
    else if (key_we)                locked_q <= (wdata != KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     drive_q <= '0;
    else if (drive_we && !locked_q) drive_q <= wdata[DRIVE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     guard_q <= '1;
    else if (guard_we && !locked_q) guard_q <= guard_q & wdata[NPINS-1:0];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int unsigned WORD  = p / PINS_PER_WORD;
    localparam int unsigned FIELD = p % PINS_PER_WORD;
    logic [MODE_W-1:0] field_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        field_q <= '0;
      else if (mode_we[WORD] && !locked_q && guard_q[p])
        field_q <= wdata[FIELD*MODE_W +: MODE_W];
    end

    assign mode_flat[p*MODE_W +: MODE_W] = field_q;
  end

  // R8: configuration frozen while locked
  assert_drive_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(drive_q));
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_flat));

  // R6: guard bits can only fall
  assert_guard_only_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((guard_q & ~$past(guard_q)) == '0));

  // R7: the key unlocks, anything else locks
  assert_key_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && wdata == KEY) |=> !locked_q);
  assert_other_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && wdata != KEY) |=> locked_q);
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned MODE_W      = 4,
  parameter int unsigned DRIVE_W     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] UNLOCK_KEY  = 32'h0000_A543
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  input  logic [NPINS-1:0]        pin_in,
  output logic [NPINS-1:0]        pin_out,
  output logic [NPINS*MODE_W-1:0] pin_mode,
  output logic [DRIVE_W-1:0]      drive_mode,
  output logic                    cfg_locked
);
  localparam int unsigned DATA_W     = 32;
  // the offset map holds two mode words, so NPINS*MODE_W must equal 64
  localparam int unsigned MODE_WORDS = (NPINS * MODE_W + DATA_W - 1) / DATA_W;

  logic [IDX_W-1:0]      idx;
  logic                  wr, rd;
  logic                  out_we;
  out_op_e               out_op;
  logic [MODE_WORDS-1:0] mode_we;
  logic [NPINS-1:0]      guard;
  logic [NPINS-1:0]      in_sync;
  logic [DATA_W-1:0]     rdata_next;

  assign req_ready = 1'b1;
  assign idx = req_addr[ADDR_W-1:2];
  assign wr  = req_valid && req_write;
  assign rd  = req_valid && !req_write;

  always_comb begin
    out_we = wr;
    unique case (idx)
      IDX_OUT:  out_op = OUT_LOAD;
      IDX_SET:  out_op = OUT_SET;
      IDX_CLR:  out_op = OUT_CLR;
      IDX_FLIP: out_op = OUT_FLIP;
      default: begin
        out_op = OUT_LOAD;
        out_we = 1'b0;
      end
    endcase
  end

  for (genvar w = 0; w < MODE_WORDS; w++) begin : g_mode_we
    assign mode_we[w] = wr && (idx == IDX_MODE_LO + IDX_W'(w));
  end

  gpio_out_reg #(.W(NPINS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (out_we),
    .op      (out_op),
    .pattern (req_wdata[NPINS-1:0]),
    .guard   (guard),
    .out_q   (pin_out)
  );

  gpio_cfg_regs #(
    .NPINS   (NPINS),
    .MODE_W  (MODE_W),
    .DRIVE_W (DRIVE_W),
    .DATA_W  (DATA_W),
    .KEY     (UNLOCK_KEY)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (req_wdata),
    .drive_we  (wr && idx == IDX_DRIVE),
    .mode_we   (mode_we),
    .guard_we  (wr && idx == IDX_GUARD),
    .key_we    (wr && idx == IDX_KEY),
    .drive_q   (drive_mode),
    .mode_flat (pin_mode),
    .guard_q   (guard),
    .locked_q  (cfg_locked)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  always_comb begin
    rdata_next = '0;
    unique case (idx)
      IDX_DRIVE:   rdata_next[DRIVE_W-1:0] = drive_mode;
      IDX_MODE_LO: rdata_next = pin_mode[0 +: DATA_W];
      IDX_MODE_HI: rdata_next = pin_mode[DATA_W +: DATA_W];
      IDX_OUT:     rdata_next[NPINS-1:0] = pin_out;
      IDX_IN:      rdata_next[NPINS-1:0] = in_sync;
      IDX_GUARD:   rdata_next[NPINS-1:0] = guard;
      IDX_KEY:     rdata_next[0] = cfg_locked;
      default:     rdata_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_next;
    end
  end

  // R10: exactly one response per accepted read
  assert_read_answers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  assert_always_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

// File: tb/gpio_lock_bank_test.sv
`timescale 1ns/1ps
module gpio_lock_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [63:0] pin_mode;
  logic [1:0]  drive_mode;
  logic        cfg_locked;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gpio_lock_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_mode(pin_mode), .drive_mode(drive_mode),
    .cfg_locked(cfg_locked)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected response: actual=%h expected=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {32'h0, rsp_rdata}, {32'h0, e});
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", {48'h0, pin_out}, 64'h0);
    check("R1 pin_mode", pin_mode, 64'h0);
    check("R1 drive_mode", {62'h0, drive_mode}, 64'h0);
    check("R1 cfg_locked", {63'h0, cfg_locked}, 64'h0);
    check("R10 req_ready", {63'h0, req_ready}, 64'h1);
    bus_read(6'h20, 32'h0000_FFFF, "R1 guard reset");
    bus_read(6'h24, 32'h0, "R1 lock reset");

    // R2 full load
    bus_write(6'h0C, 32'hDEAD_1234);
    check("R2 pin_out load", {48'h0, pin_out}, 64'h1234);
    bus_read(6'h0C, 32'h0000_1234, "R2 readback");

    // R3 aliases
    bus_write(6'h10, 32'h0000_00F0);
    check("R3 set", {48'h0, pin_out}, 64'h12F4);
    bus_write(6'h14, 32'h0000_1030);
    check("R3 clear", {48'h0, pin_out}, 64'h02C4);
    bus_write(6'h18, 32'h0000_FF00);
    check("R3 toggle", {48'h0, pin_out}, 64'hFDC4);
    bus_read(6'h18, 32'h0, "R10 alias reads zero");

    // R4 mode layout
    bus_write(6'h04, 32'h7654_3210);
    bus_write(6'h08, 32'hFEDC_BA98);
    check("R4 pin_mode", pin_mode, 64'hFEDC_BA98_7654_3210);
    bus_read(6'h04, 32'h7654_3210, "R4 low word");
    bus_read(6'h08, 32'hFEDC_BA98, "R4 high word");

    // R5 drive field
    bus_write(6'h00, 32'h0000_0002);
    check("R5 drive high", {62'h0, drive_mode}, 64'h2);
    bus_write(6'h00, 32'hFFFF_FFFD);
    check("R5 drive lowest", {62'h0, drive_mode}, 64'h1);
    bus_read(6'h00, 32'h0000_0001, "R5 readback");

    // R9 synchronized input
    pin_in = 16'hA5C3;
    repeat (3) @(negedge clk);
    bus_read(6'h1C, 32'h0000_A5C3, "R9 input");
    pin_in = 16'h1111;
    bus_read(6'h1C, 32'h0000_A5C3, "R9 one edge late");
    bus_read(6'h1C, 32'h0000_1111, "R9 two edges");

    // R6 pin guards
    bus_write(6'h20, 32'hFFFF_FF0F);
    bus_read(6'h20, 32'h0000_FF0F, "R6 guard cleared");
    bus_write(6'h20, 32'h0000_FFFF);
    bus_read(6'h20, 32'h0000_FF0F, "R6 guard cannot set");
    bus_write(6'h0C, 32'h0);
    check("R6 guarded load", {48'h0, pin_out}, 64'h00C0);
    bus_write(6'h18, 32'h0000_FFFF);
    check("R6 guarded toggle", {48'h0, pin_out}, 64'hFFCF);
    bus_write(6'h04, 32'h0);
    bus_read(6'h04, 32'h7654_0000, "R6 guarded modes");

    // R7 / R8 lock
    bus_write(6'h24, 32'h0);
    check("R7 locked", {63'h0, cfg_locked}, 64'h1);
    bus_read(6'h24, 32'h1, "R7 lock reads one");
    bus_write(6'h00, 32'h3);
    check("R8 drive frozen", {62'h0, drive_mode}, 64'h1);
    bus_write(6'h08, 32'h0);
    check("R8 modes frozen", pin_mode, 64'hFEDC_BA98_7654_0000);
    bus_write(6'h20, 32'h0);
    bus_read(6'h20, 32'h0000_FF0F, "R8 guard frozen");
    bus_write(6'h0C, 32'h0000_0001);
    check("R8 data still writable", {48'h0, pin_out}, 64'h00C1);
    bus_write(6'h24, 32'h0000_A543);
    check("R7 unlocked", {63'h0, cfg_locked}, 64'h0);
    bus_read(6'h24, 32'h0, "R7 lock reads zero");
    bus_write(6'h00, 32'h3);
    check("R8 drive after unlock", {62'h0, drive_mode}, 64'h3);
    bus_write(6'h24, 32'h0000_A542);
    check("R7 wrong key locks", {63'h0, cfg_locked}, 64'h1);

    // R10 unmapped
    bus_read(6'h38, 32'h0, "R10 unmapped read");
    bus_write(6'h3C, 32'hFFFF_FFFF);
    check("R10 unmapped write", {48'h0, pin_out}, 64'h00C1);

    repeat (3) @(negedge clk);
    check("R10 all responses seen", {32'h0, 32'(exp_q.size())}, 64'h0);
    finish_run();
  end
endmodule